// File: doc/BRIEF.md
# Three-Level MLT-3 Line Encoder

This block turns a serial NRZ bit stream into a three-level line code for a transmit driver. One bit arrives per clock, with a strobe that marks it valid. The output is a registered 2-bit signed level: negative, zero or positive.

A 1 moves the line to the next level of a repeating four-step cycle: negative, zero, positive, zero, and then negative again. A 0 leaves the line where it is. Zero occurs twice in each period. The block keeps a 2-bit phase so that it knows which way to go when it leaves zero. Analog drive, waveshaping, clock recovery and receive-side decoding are handled elsewhere.

Top module: `mlt3_line_encoder`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, `level_out` becomes 2'b00 (zero) and the phase becomes zero-going-up. The first valid 1 after reset therefore gives positive (2'b01).
- R2: On a clock edge where `bit_valid` is low, `level_out` and the phase keep their values, whatever `bit_in` is.
- R3: A valid 0 (`bit_valid`=1, `bit_in`=0) leaves `level_out` unchanged at negative, zero or positive.
- R4: Each valid 1 advances the output one step in the fixed order negative, zero, positive, zero, negative and so on. It never jumps directly between negative and positive.
- R5: The level encoding is 2'b11 for negative, 2'b00 for zero and 2'b01 for positive. The code 2'b10 never appears.
- R6: `level_out` is registered. It takes the level caused by an input bit at the rising clock edge that samples that bit, which is one clock of latency.
- R7: Direction out of zero depends on where the line came from. Zero reached from negative steps to positive, and zero reached from positive steps to negative.
- R8: Four valid 1s in a row return `level_out` to the level it had before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Marks `bit_in` as a valid NRZ bit this cycle |
| bit_in | input | 1 | Serial NRZ data bit |
| level_out | output | 2 | Line level: 11 negative, 00 zero, 01 positive |

## Verification
The stream is tried in four forms, each aimed at a different fault:
- Long runs of 1s walk the whole four-phase cycle. They show a wrong step order, and a missing distinction between the two zero phases, because the step after each zero alternates direction.
- Runs of 0s and cycles with the strobe low, with `bit_in` toggling, show whether the hold and the strobe gating leak.
- A valid 1 right after reset shows the starting phase.
- A long seeded random mix of strobe and data, compared against a bench model of the phase, covers every transition from every phase.

// File: rtl/mlt3_line_encoder.sv
module mlt3_line_encoder #(
  parameter logic [1:0] RESET_PHASE = 2'd1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic [1:0] level_out
);
  localparam logic [1:0] LVL_NEG  = 2'b11;
  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;

  logic [1:0] phase_q, phase_d;
  logic [1:0] level_q;

  function automatic logic [1:0] phase_level(input logic [1:0] ph);
    case (ph)
      2'd0:    phase_level = LVL_NEG;
      2'd2:    phase_level = LVL_POS;
      default: phase_level = LVL_ZERO;
    endcase
  endfunction

  assign phase_d = (bit_valid && bit_in) ? phase_q + 2'd1 : phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= RESET_PHASE;
      level_q <= phase_level(RESET_PHASE);
    end else begin
      phase_q <= phase_d;
      level_q <= phase_level(phase_d);
    end
  end

  assign level_out = level_q;

  a_r5_legal_code: assert property (@(posedge clk) disable iff (rst)
    level_out != 2'b10);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(level_out));

  a_r3_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_in) |=> $stable(level_out));

  a_r4_one_moves: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in) |=> level_out != $past(level_out));

  a_r4_neg_to_zero: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && level_out == LVL_NEG) |=> level_out == LVL_ZERO);

  a_r4_pos_to_zero: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && level_out == LVL_POS) |=> level_out == LVL_ZERO);
endmodule

// File: tb/tb_mlt3_line_encoder.sv
module tb_mlt3_line_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic [1:0] level_out;

  int checks = 0;
  int failures = 0;
  logic [1:0] m_phase;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mlt3_line_encoder dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .level_out(level_out)
  );

  function automatic logic [1:0] exp_level(input logic [1:0] ph);
    case (ph)
      2'd0: return 2'b11;
      2'd2: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (level_out !== exp) begin
      failures++;
      $display("FAIL %s: level_out=%b expected=%b", req, level_out, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input string req);
    bit_valid = v;
    bit_in = b;
    if (v && b) m_phase = m_phase + 2'd1;
    @(negedge clk);
    check(req, exp_level(m_phase));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_phase = 2'd1;
    check("R1", 2'b00);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: expired, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1559));
    @(negedge clk);
    do_reset();
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, "R4");
    step(1'b1, 1'b1, "R8");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, "R4");
    for (int i = 0; i < 6; i++) step(1'b0, i[0], "R2");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, "R6");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, "R5");
    do_reset();
    step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 4000; i++) begin
      logic v, b;
      v = ($urandom % 4) != 0;
      b = $urandom % 2;
      step(v, b, "R4");
      checks++;
      if (level_out == 2'b10) begin
        failures++;
        $display("FAIL R5: level_out=%b expected=not 10", level_out);
      end
      if (i % 997 == 996) do_reset();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule